// File: doc/BRIEF.md
# Raster-Driven Frame Memory Arbiter

This block steps a display raster through a frame much larger than the picture it shows, and uses the raster position to share one single-port external memory between two users. The memory completes one access per clock. While the raster is inside the square image window, the memory serves display reads at the address built from the current row, the current column and the selected display bank. On every other cycle of the raster, the memory is free for pending input pixels. The block takes the next entry from an input FIFO and writes it to the address that entry carries.

Read data comes back one cycle after its address. The block delays its window decision by one register so that the pixel output shows the returned byte for image cycles and black for all other cycles. It produces horizontal and vertical sync pulses over fixed column and line windows. These pulses pass through the same delay register so that they line up with the pixel stream. By default the raster is 759 columns by 527 lines around a 256x256 picture, so about two thirds of each line is free for writes.

Top module: `vga_mem_arbiter`

## Requirements
- R1: The column counter runs from 0 to H_TOTAL-1 and then wraps to 0. The row counter advances by one on each wrap and returns to 0 after V_TOTAL-1. During image cycles, the counters appear at the address port as {disp_bank, row[ROW_W-1:0], col[COL_W-1:0]}, with the bank as the top bit.
- R2: When col < IMG_W and row < IMG_H (an image cycle), mem_we and fifo_pop are 0 whatever the FIFO state, and the memory address is the display read address.
- R3: On a cycle outside the image window with fifo_empty at 0, mem_we and fifo_pop are both 1 in that same cycle, mem_addr equals fifo_addr and mem_wdata equals fifo_data.
- R4: On a cycle outside the image window with fifo_empty at 1, mem_we and fifo_pop are both 0.
- R5: After an image cycle, pixel equals the mem_rdata returned for that cycle's read. After any cycle outside the image window, pixel is 0 (black).
- R6: hsync is 1 in the cycle after any cycle whose column lies in [HS_START, HS_START+HS_WIDTH), and 0 otherwise.
- R7: vsync is 1 in the cycle after any cycle whose row lies in [VS_START, VS_START+VS_WIDTH), and 0 otherwise.
- R8: While rst_n is 0, the counters hold at row 0, column 0. pixel, hsync and vsync are 0, and no write or pop is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory and pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_bank | input | 1 | Frame buffer bank the display reads from |
| fifo_empty | input | 1 | Input FIFO holds no entry |
| fifo_addr | input | ADDR_W | Memory address of the FIFO head entry |
| fifo_data | input | DATA_W | Pixel byte of the FIFO head entry |
| fifo_pop | output | 1 | Removes the FIFO head entry this cycle |
| mem_addr | output | ADDR_W | Memory address for this cycle |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after its address |
| pixel | output | DATA_W | Display pixel, black outside the image |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bench uses a reduced raster (12 columns by 8 lines around a 4x4 image) and checks every cycle of three full frames against counters the bench keeps itself. In the first frame the FIFO is always empty, which shows that blank cycles stay idle (R4). In the second frame the FIFO is always full, which shows that image cycles never yield to writes and that every blank cycle writes (R2, R3). The third frame uses an irregular empty pattern, which shows that the write decision follows the FIFO state cycle by cycle. The memory model returns a value that is a function of the address it was given. This exposes any error in the one-cycle alignment of pixel and sync.

// File: rtl/vga_mem_arbiter.sv
module vga_mem_arbiter #(
  parameter int H_TOTAL  = 759,
  parameter int V_TOTAL  = 527,
  parameter int IMG_W    = 256,
  parameter int IMG_H    = 256,
  parameter int HS_START = 680,
  parameter int HS_WIDTH = 64,
  parameter int VS_START = 500,
  parameter int VS_WIDTH = 2,
  parameter int DATA_W   = 8,
  localparam int COL_W  = $clog2(IMG_W),
  localparam int ROW_W  = $clog2(IMG_H),
  localparam int ADDR_W = 1 + ROW_W + COL_W,
  localparam int HC_W   = $clog2(H_TOTAL),
  localparam int VC_W   = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_bank,
  input  logic              fifo_empty,
  input  logic [ADDR_W-1:0] fifo_addr,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] pixel,
  output logic              hsync,
  output logic              vsync
);

  logic [HC_W-1:0] col;
  logic [VC_W-1:0] row;
  logic            img_active;
  logic            active_q;
  logic            line_end, frame_end;
  logic            hs_now, vs_now;

  assign line_end  = (col == HC_W'(H_TOTAL - 1));
  assign frame_end = (row == VC_W'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (line_end) begin
      col <= '0;
      row <= frame_end ? '0 : row + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  assign img_active = (col < HC_W'(IMG_W)) && (row < VC_W'(IMG_H));
  assign hs_now = (col >= HC_W'(HS_START)) && (col < HC_W'(HS_START + HS_WIDTH));
  assign vs_now = (row >= VC_W'(VS_START)) && (row < VC_W'(VS_START + VS_WIDTH));

  assign mem_we    = !img_active && !fifo_empty;
  assign fifo_pop  = mem_we;
  assign mem_wdata = fifo_data;
  assign mem_addr  = img_active ? {disp_bank, row[ROW_W-1:0], col[COL_W-1:0]}
                                : fifo_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hsync    <= 1'b0;
      vsync    <= 1'b0;
    end else begin
      active_q <= img_active;
      hsync    <= hs_now;
      vsync    <= vs_now;
    end
  end

  assign pixel = active_q ? mem_rdata : '0;

endmodule

module vga_mem_arbiter_chk #(
  parameter int H_TOTAL = 759,
  parameter int V_TOTAL = 527,
  parameter int HC_W    = 10,
  parameter int VC_W    = 10,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HC_W-1:0]   col,
  input logic [VC_W-1:0]   row,
  input logic              img_active,
  input logic              fifo_empty,
  input logic              fifo_pop,
  input logic              mem_we,
  input logic [ADDR_W-1:0] fifo_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] pixel
);

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (col == HC_W'(H_TOTAL - 1)) |=> (col == '0)); // R1
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col == HC_W'(H_TOTAL - 1) && row != VC_W'(V_TOTAL - 1)) |=> (row == $past(row) + 1'b1)); // R1
  AST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    img_active |-> !mem_we); // R2
  AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == fifo_addr)); // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop); // R4
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !img_active |=> (pixel == '0)); // R5

endmodule

bind vga_mem_arbiter vga_mem_arbiter_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HC_W(HC_W), .VC_W(VC_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .col(col), .row(row), .img_active(img_active),
  .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .mem_we(mem_we),
  .fifo_addr(fifo_addr), .mem_addr(mem_addr), .pixel(pixel)
);

// File: tb/vga_mem_arbiter_tb.sv
`timescale 1ns/1ps
module vga_mem_arbiter_tb_top;
  localparam int HT = 12, VT = 8, IW = 4, IH = 4;
  localparam int HSS = 8, HSW = 2, VSS = 6, VSW = 1;
  localparam int AW = 5, DW = 8;

  logic clk = 0, rst_n = 0, disp_bank = 0, fifo_empty = 1;
  logic [AW-1:0] fifo_addr = '0, mem_addr;
  logic [DW-1:0] fifo_data = '0, mem_wdata, mem_rdata = '0, pixel;
  logic fifo_pop, mem_we, hsync, vsync;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vga_mem_arbiter #(.H_TOTAL(HT), .V_TOTAL(VT), .IMG_W(IW), .IMG_H(IH),
    .HS_START(HSS), .HS_WIDTH(HSW), .VS_START(VSS), .VS_WIDTH(VSW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_bank(disp_bank), .fifo_empty(fifo_empty),
    .fifo_addr(fifo_addr), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .pixel(pixel), .hsync(hsync), .vsync(vsync));

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    return DW'(a * 7 + 3);
  endfunction

  always_ff @(posedge clk) mem_rdata <= rd_val(mem_addr);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int ec = 0, er = 0, wcnt = 0;
  bit pv_act = 0, pv_hs = 0, pv_vs = 0;
  logic [AW-1:0] pv_addr = '0;

  task automatic step(input bit empty, input bit bank);
    bit act, we;
    logic [AW-1:0] ea;
    fifo_empty = empty;
    disp_bank  = bank;
    fifo_addr  = AW'(wcnt * 3);
    fifo_data  = DW'(wcnt + 8'h40);
    #1;
    act = (ec < IW) && (er < IH);
    we  = !act && !empty;
    ea  = act ? {bank, 2'(er), 2'(ec)} : fifo_addr;
    if (act) begin
      chk("R1 read address", int'(mem_addr), int'(ea));
      chk("R2 no write in image", int'(mem_we), 0);
      chk("R2 no pop in image", int'(fifo_pop), 0);
    end else if (!empty) begin
      chk("R3 write enable", int'(mem_we), 1);
      chk("R3 pop", int'(fifo_pop), 1);
      chk("R3 write address", int'(mem_addr), int'(ea));
      chk("R3 write data", int'(mem_wdata), int'(fifo_data));
    end else begin
      chk("R4 idle write", int'(mem_we), 0);
      chk("R4 idle pop", int'(fifo_pop), 0);
    end
    chk("R5 pixel", int'(pixel), pv_act ? int'(rd_val(pv_addr)) : 0);
    chk("R6 hsync", int'(hsync), int'(pv_hs));
    chk("R7 vsync", int'(vsync), int'(pv_vs));
    pv_act  = act;
    pv_addr = ea;
    pv_hs   = (ec >= HSS) && (ec < HSS + HSW);
    pv_vs   = (er >= VSS) && (er < VSS + VSW);
    if (ec == HT - 1) begin
      ec = 0;
      er = (er == VT - 1) ? 0 : er + 1;
    end else ec++;
    wcnt++;
    we = we;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    fifo_empty = 0;
    disp_bank  = 1;
    fifo_addr  = 5'd9;
    #1;
    chk("R8 reset pixel", int'(pixel), 0);
    chk("R8 reset hsync", int'(hsync), 0);
    chk("R8 reset vsync", int'(vsync), 0);
    chk("R8 reset no write", int'(mem_we), 0);
    chk("R8 reset address origin", int'(mem_addr), 5'b10000);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < HT * VT; i++) step(1'b1, 1'b0);
    for (int i = 0; i < HT * VT; i++) step(1'b0, 1'b1);
    for (int i = 0; i < HT * VT; i++) step((i % 3 == 0) || (i % 7 == 2), i[3]);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule